// File: doc/BRIEF.md
# Completion-Time Exception Selector

The selector is evaluated whenever an instruction completes. It looks at five exception sources and picks the one to take. The sources are an instruction-address breakpoint, single-step and branch trace, a system-management request, a thermal alarm and a performance-counter limit. Each source has its own enable. The block registers a one-cycle take strobe together with the 20-bit vector offset of the chosen exception. The rest of the core uses that offset to redirect fetch. Saving and restoring machine state is left to the surrounding logic.

The system-management and thermal requests are level-sensitive and are gated by the external-interrupt enable. Once the block takes either of them, it masks its own copy of that enable. The mask stays in place until software drops the enable for at least one cycle and raises it again. This keeps a request that is still asserted from being taken a second time.

Top module: `exc_vector_sel`

## Requirements
- R1: While `rst_ni` is low, `take_o` is 0 and `vec_o` is 0 whatever the inputs are.
- R2: A trace exception (offset 0x00D00) is selected at a completion (`cmpl_i`=1) in two cases: `se_i`=1, or `bte_i`=1 with `cmpl_br_i`=1. With `bte_i` alone, a completion that is not a branch raises no trace.
- R3: A completion with `cmpl_sync_i`=1 never selects trace, even when `se_i` or `bte_i` is set.
- R4: A performance-monitor exception (offset 0x00F00) is selected at a completion when `pm_limit_i`=1 and `pm_ie_i`=1.
- R5: A breakpoint exception (offset 0x01300) is selected at a completion when three conditions hold: `bkpt_addr_i` equals `next_ea_i` (both carry the 30 upper word-address bits), `bkpt_te_i` equals `ir_i`, and `bkpt_en_i`=1.
- R6: A system-management exception (offset 0x01400) is selected at a completion when `smi_i`=1 and the effective external enable is 1. The effective enable is `ee_i`=1 with the internal mask clear.
- R7: A thermal exception (offset 0x01700) is selected at a completion when `therm_en_i`=1, at least one of `thr1_hit_i` or `thr2_hit_i` is 1, and the effective external enable is 1.
- R8: When several sources qualify in one cycle, the winner follows this order, highest first: breakpoint, trace, system-management, thermal, performance monitor.
- R9: The selection made at clock edge k appears as `take_o`=1 with its offset on `vec_o` for exactly the cycle after edge k. In every other cycle `vec_o` is 0. Offset 0x00E00 never appears.
- R10: Taking a system-management or thermal exception sets the internal mask. The mask clears in any cycle that samples `ee_i`=0. While the mask is set, neither of those two sources can be selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| se_i | input | 1 | Single-step trace enable |
| bte_i | input | 1 | Branch trace enable |
| ee_i | input | 1 | External-interrupt enable |
| ir_i | input | 1 | Instruction translation enable |
| cmpl_i | input | 1 | An instruction completes this cycle |
| cmpl_br_i | input | 1 | The completing instruction is a branch |
| cmpl_sync_i | input | 1 | The completing instruction is an instruction-synchronize |
| next_ea_i | input | 30 | Upper word-address bits of the next instruction to complete |
| pm_limit_i | input | 1 | Performance counter reached its limit |
| pm_ie_i | input | 1 | Performance-monitor interrupt enable |
| bkpt_addr_i | input | 30 | Breakpoint word address |
| bkpt_te_i | input | 1 | Translation mode the breakpoint applies to |
| bkpt_en_i | input | 1 | Breakpoint enable |
| smi_i | input | 1 | System-management request level |
| therm_en_i | input | 1 | Thermal management enable |
| thr1_hit_i | input | 1 | First thermal threshold exceeded |
| thr2_hit_i | input | 1 | Second thermal threshold exceeded |
| take_o | output | 1 | Take-exception strobe |
| vec_o | output | 20 | Vector offset of the taken exception |

## Verification
The collisions that matter most are a breakpoint hit on a completing branch while branch trace is on, and a system-management request raised together with a thermal alarm. Directed steps stack the sources one on top of another and then remove the winner each time, so every level of the ordering is exposed. A long random phase follows, with the breakpoint address forced to match half of the time. Every cycle is compared against a behavioural model that applies the priority and the mask update, so a wrong winner, or a mask left set after the enable drops, shows up as a miscompare in the offset.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

  localparam int unsigned VEC_W      = 20;
  localparam int unsigned NUM_CAUSES = 5;

  // index order is priority order, 0 highest
  typedef enum logic [2:0] {
    CAUSE_BKPT  = 3'd0,
    CAUSE_TRACE = 3'd1,
    CAUSE_SMI   = 3'd2,
    CAUSE_THERM = 3'd3,
    CAUSE_PERF  = 3'd4
  } cause_e;

  localparam logic [VEC_W-1:0] VEC_TRACE = 20'h00D00;
  localparam logic [VEC_W-1:0] VEC_PERF  = 20'h00F00;
  localparam logic [VEC_W-1:0] VEC_BKPT  = 20'h01300;
  localparam logic [VEC_W-1:0] VEC_SMI   = 20'h01400;
  localparam logic [VEC_W-1:0] VEC_THERM = 20'h01700;

  function automatic logic [VEC_W-1:0] vec_of(input logic [2:0] idx);
    case (cause_e'(idx))
      CAUSE_BKPT:  vec_of = VEC_BKPT;
      CAUSE_TRACE: vec_of = VEC_TRACE;
      CAUSE_SMI:   vec_of = VEC_SMI;
      CAUSE_THERM: vec_of = VEC_THERM;
      CAUSE_PERF:  vec_of = VEC_PERF;
      default:     vec_of = '0;
    endcase
  endfunction

  function automatic logic ee_gated(input logic [2:0] idx);
    ee_gated = (cause_e'(idx) == CAUSE_SMI) || (cause_e'(idx) == CAUSE_THERM);
  endfunction

endpackage

// File: rtl/exc_bkpt_match.sv
module exc_bkpt_match #(
  parameter int unsigned AW = 30
) (
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] bkpt_addr_i,
  input  logic          bkpt_te_i,
  input  logic          bkpt_en_i,
  input  logic          ir_i,
  output logic          hit_o
);
  logic addr_eq;
  assign addr_eq = (ea_i == bkpt_addr_i);
  assign hit_o   = bkpt_en_i & addr_eq & (bkpt_te_i == ir_i);
endmodule

// File: rtl/exc_cond_eval.sv
module exc_cond_eval
  import exc_sel_pkg::*;
(
  input  logic                  cmpl_i,
  input  logic                  cmpl_br_i,
  input  logic                  cmpl_sync_i,
  input  logic                  se_i,
  input  logic                  bte_i,
  input  logic                  ee_eff_i,
  input  logic                  bkpt_hit_i,
  input  logic                  smi_i,
  input  logic                  therm_en_i,
  input  logic                  thr1_hit_i,
  input  logic                  thr2_hit_i,
  input  logic                  pm_limit_i,
  input  logic                  pm_ie_i,
  output logic [NUM_CAUSES-1:0] req_o
);
  logic trace_c, smi_c, therm_c, perf_c;

  // sync completion suppresses trace
  assign trace_c = ~cmpl_sync_i & (se_i | (bte_i & cmpl_br_i));
  assign smi_c   = smi_i & ee_eff_i;
  assign therm_c = therm_en_i & (thr1_hit_i | thr2_hit_i) & ee_eff_i;
  assign perf_c  = pm_limit_i & pm_ie_i;

  always_comb begin
    req_o              = '0;
    req_o[CAUSE_BKPT]  = cmpl_i & bkpt_hit_i;
    req_o[CAUSE_TRACE] = cmpl_i & trace_c;
    req_o[CAUSE_SMI]   = cmpl_i & smi_c;
    req_o[CAUSE_THERM] = cmpl_i & therm_c;
    req_o[CAUSE_PERF]  = cmpl_i & perf_c;
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_sel_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             se_i,
  input  logic             bte_i,
  input  logic             ee_i,
  input  logic             ir_i,
  input  logic             cmpl_i,
  input  logic             cmpl_br_i,
  input  logic             cmpl_sync_i,
  input  logic [AW-1:0]    next_ea_i,
  input  logic             pm_limit_i,
  input  logic             pm_ie_i,
  input  logic [AW-1:0]    bkpt_addr_i,
  input  logic             bkpt_te_i,
  input  logic             bkpt_en_i,
  input  logic             smi_i,
  input  logic             therm_en_i,
  input  logic             thr1_hit_i,
  input  logic             thr2_hit_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IDX_W = $clog2(NUM_CAUSES);

  logic                  ee_mask_q;
  logic                  ee_eff;
  logic                  bkpt_hit;
  logic [NUM_CAUSES-1:0] req;
  logic [NUM_CAUSES-1:0] grant;
  logic                  any;
  logic [VEC_W-1:0]      vec_d;
  logic                  gated_d;
  logic                  take_q;
  logic [VEC_W-1:0]      vec_q;

  assign ee_eff = ee_i & ~ee_mask_q;

  exc_bkpt_match #(.AW(AW)) u_bkpt (
    .ea_i        (next_ea_i),
    .bkpt_addr_i (bkpt_addr_i),
    .bkpt_te_i   (bkpt_te_i),
    .bkpt_en_i   (bkpt_en_i),
    .ir_i        (ir_i),
    .hit_o       (bkpt_hit)
  );

  exc_cond_eval u_cond (
    .cmpl_i      (cmpl_i),
    .cmpl_br_i   (cmpl_br_i),
    .cmpl_sync_i (cmpl_sync_i),
    .se_i        (se_i),
    .bte_i       (bte_i),
    .ee_eff_i    (ee_eff),
    .bkpt_hit_i  (bkpt_hit),
    .smi_i       (smi_i),
    .therm_en_i  (therm_en_i),
    .thr1_hit_i  (thr1_hit_i),
    .thr2_hit_i  (thr2_hit_i),
    .pm_limit_i  (pm_limit_i),
    .pm_ie_i     (pm_ie_i),
    .req_o       (req)
  );

  exc_prio_pick #(.N(NUM_CAUSES)) u_pick (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (any)
  );

  // grant is one-hot, so OR-reduce the per-cause vectors
  always_comb begin
    vec_d   = '0;
    gated_d = 1'b0;
    for (int i = 0; i < NUM_CAUSES; i++) begin
      if (grant[i]) begin
        vec_d   = vec_d | vec_of(IDX_W'(i));
        gated_d = gated_d | ee_gated(IDX_W'(i));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q    <= 1'b0;
      vec_q     <= '0;
      ee_mask_q <= 1'b0;
    end else begin
      take_q <= any;
      vec_q  <= vec_d;
      if (!ee_i)
        ee_mask_q <= 1'b0;
      else if (any && gated_d)
        ee_mask_q <= 1'b1;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/exc_vector_sel_chk.sv
module exc_vector_sel_chk #(
  parameter int unsigned AW = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          se_i,
  input logic          ee_i,
  input logic          ir_i,
  input logic          cmpl_i,
  input logic          cmpl_sync_i,
  input logic [AW-1:0] next_ea_i,
  input logic          pm_limit_i,
  input logic          pm_ie_i,
  input logic [AW-1:0] bkpt_addr_i,
  input logic          bkpt_te_i,
  input logic          bkpt_en_i,
  input logic          smi_i,
  input logic          therm_en_i,
  input logic          thr1_hit_i,
  input logic          thr2_hit_i,
  input logic          take_o,
  input logic [19:0]   vec_o
);
  logic ee_src_out;
  assign ee_src_out = take_o && (vec_o == 20'h01400 || vec_o == 20'h01700);

  AST_BKPT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && bkpt_en_i && bkpt_te_i == ir_i && bkpt_addr_i == next_ea_i)
    |=> (take_o && vec_o == 20'h01300)); // R5
  AST_SYNC_NO_TRACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o == 20'h00D00) |-> !$past(cmpl_sync_i)); // R3
  AST_STEP_TRACES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && se_i && !cmpl_sync_i) |=> take_o); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> vec_o == 20'h0); // R9
  AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o != 20'h00E00); // R9
  AST_TAKE_AT_CMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(cmpl_i)); // R9
  AST_PERF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o == 20'h00F00) |-> $past(pm_limit_i && pm_ie_i)); // R4
  AST_SMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o == 20'h01400) |-> $past(smi_i && ee_i)); // R6
  AST_THERM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o == 20'h01700)
    |-> $past(therm_en_i && ee_i && (thr1_hit_i || thr2_hit_i))); // R7
  AST_NO_RETAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_src_out |=> !ee_src_out); // R10
endmodule

bind exc_vector_sel exc_vector_sel_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .se_i        (se_i),
  .ee_i        (ee_i),
  .ir_i        (ir_i),
  .cmpl_i      (cmpl_i),
  .cmpl_sync_i (cmpl_sync_i),
  .next_ea_i   (next_ea_i),
  .pm_limit_i  (pm_limit_i),
  .pm_ie_i     (pm_ie_i),
  .bkpt_addr_i (bkpt_addr_i),
  .bkpt_te_i   (bkpt_te_i),
  .bkpt_en_i   (bkpt_en_i),
  .smi_i       (smi_i),
  .therm_en_i  (therm_en_i),
  .thr1_hit_i  (thr1_hit_i),
  .thr2_hit_i  (thr2_hit_i),
  .take_o      (take_o),
  .vec_o       (vec_o)
);

// File: tb/exc_vector_sel_test.sv
`timescale 1ns/1ps
module exc_vector_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        se, bte, ee, ir, cmpl, br, sync;
  logic [29:0] ea, baddr;
  logic        pm_lim, pm_ie, bte_m, ben, smi, ten, t1, t2;
  logic        take;
  logic [19:0] vec;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R1";

  logic        m_take, m_mask, eeq;
  logic [19:0] m_vec;

  always #2.5 clk = ~clk;

  exc_vector_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .se_i(se), .bte_i(bte), .ee_i(ee), .ir_i(ir),
    .cmpl_i(cmpl), .cmpl_br_i(br), .cmpl_sync_i(sync), .next_ea_i(ea),
    .pm_limit_i(pm_lim), .pm_ie_i(pm_ie), .bkpt_addr_i(baddr), .bkpt_te_i(bte_m),
    .bkpt_en_i(ben), .smi_i(smi), .therm_en_i(ten), .thr1_hit_i(t1), .thr2_hit_i(t2),
    .take_o(take), .vec_o(vec)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_take = 0; m_vec = 0; m_mask = 0;
    end else begin
      eeq   = ee && !m_mask;
      m_vec = 20'h0;
      if (cmpl) begin
        if (ben && bte_m == ir && baddr == ea)          m_vec = 20'h01300;
        else if (!sync && (se || (bte && br)))          m_vec = 20'h00D00;
        else if (smi && eeq)                            m_vec = 20'h01400;
        else if (ten && (t1 || t2) && eeq)              m_vec = 20'h01700;
        else if (pm_lim && pm_ie)                       m_vec = 20'h00F00;
      end
      m_take = (m_vec != 0);
      if (!ee) m_mask = 0;
      else if (m_vec == 20'h01400 || m_vec == 20'h01700) m_mask = 1;
    end
  end

  task automatic clr();
    se = 0; bte = 0; ee = 0; ir = 0; cmpl = 0; br = 0; sync = 0;
    ea = '0; baddr = '1; pm_lim = 0; pm_ie = 0; bte_m = 0; ben = 0;
    smi = 0; ten = 0; t1 = 0; t2 = 0;
  endtask

  // advance one edge, compare at the following falling edge
  task automatic step(input string req);
    cur_req = req;
    @(negedge clk);
    n_chk++;
    if (take !== m_take || vec !== m_vec) begin
      n_fail++;
      $display("FAIL %s: take=%0b vec=%05h expected take=%0b vec=%05h",
               req, take, vec, m_take, m_vec);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    // R1: exceptions requested while reset is held
    se = 1; cmpl = 1; smi = 1; ee = 1;
    step("R1"); step("R1");
    if (take !== 1'b0 || vec !== 20'h0) begin
      n_fail++;
      $display("FAIL R1: take=%0b vec=%05h expected take=0 vec=00000", take, vec);
    end
    n_chk++;
    clr(); rst_n = 1;
    step("R1");

    // R2 trace
    se = 1; cmpl = 1; step("R2");
    clr(); bte = 1; cmpl = 1; br = 1; step("R2");
    br = 0; step("R2");
    clr(); step("R9");
    // R3 sync suppresses trace
    se = 1; bte = 1; br = 1; cmpl = 1; sync = 1; step("R3");
    clr();
    // R4
    pm_lim = 1; pm_ie = 1; cmpl = 1; step("R4");
    pm_ie = 0; step("R4");
    clr();
    // R5 breakpoint
    ea = 30'h1234_567; baddr = 30'h1234_567; ben = 1; bte_m = 1; ir = 1; cmpl = 1; step("R5");
    ir = 0; step("R5");
    ir = 1; ben = 0; step("R5");
    ben = 1; baddr = 30'h2234_567; step("R5");
    baddr = 30'h1234_566; step("R5");
    clr();
    // R6
    smi = 1; cmpl = 1; step("R6");
    ee = 1; step("R6");
    clr(); step("R9");
    // R7
    ten = 1; t1 = 1; ee = 1; cmpl = 1; step("R7");
    clr(); step("R7");
    ten = 1; t2 = 1; ee = 1; cmpl = 1; step("R7");
    clr(); step("R7");
    ten = 0; t1 = 1; t2 = 1; ee = 1; cmpl = 1; step("R7");
    clr(); step("R7");
    // R8 stack all, peel winners
    ee = 1; cmpl = 1; ea = 30'h77; baddr = 30'h77; ben = 1;
    se = 1; smi = 1; ten = 1; t1 = 1; pm_lim = 1; pm_ie = 1; step("R8");
    ben = 0; step("R8");
    se = 0; step("R8");
    ee = 0; step("R8");
    ee = 1; smi = 0; step("R8");
    ee = 0; step("R8");
    clr(); step("R8");
    // R10 level request held
    ee = 1; smi = 1; cmpl = 1;
    step("R10"); step("R10"); step("R10");
    ten = 1; t2 = 1; step("R10");
    ee = 0; step("R10");
    ee = 1; step("R10"); step("R10");
    clr(); step("R10");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      se = r[0] & r[1]; bte = r[2]; br = r[3]; sync = r[4] & r[5];
      ee = r[6] | r[7]; ir = r[8]; cmpl = r[9] | r[10];
      pm_lim = r[11]; pm_ie = r[12]; bte_m = r[13]; ben = r[14] & r[15];
      smi = r[16]; ten = r[17]; t1 = r[18] & r[19]; t2 = r[20] & r[21];
      ea = 30'($urandom);
      baddr = r[22] ? ea : 30'($urandom);
      step("R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule